// File: doc/BRIEF.md
# MDIO Management Master with Single Command Register

This block runs PHY management transactions from one 32-bit command/status word on a simple register bus. Software writes the word with an opcode, a PHY address, a register address and, for writes, the data. It then sets the launch bit. The block produces the management clock from the system clock and shifts out a Clause 22 management frame. It turns the data line around for reads and clears the busy bit when the frame is over.

A read puts the sixteen bits it captured into the low half of the same word. It also raises a failure flag when no PHY pulls the line low in the turnaround slot. The word is always visible on the read port, so software polls it until busy drops. While a frame is running, the word is locked against bus writes.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 0, MDC is low and MDIO is not driven. While busy (bit 29) is clear, a bus write stores all 32 bits, and they read back on `rd_data_o` the following cycle.
- R2: A write with bit 29 set while idle launches a frame and sets busy. A write with bit 29 clear produces no MDC toggling and no MDIO drive.
- R3: The frame is 64 bits, most significant first: 32 ones, then 0 then 1, then the two opcode bits 27:26 (2 = read sends 1,0; 1 = write sends 0,1), then PHY address bits 25:21, register address bits 20:16, and the turnaround. For a write the turnaround is 1,0 and data bits 15:0 follow.
- R4: While busy, MDC toggles every HALF_DIV system clocks, giving a period of 2*HALF_DIV. MDIO output and its enable change only while MDC is low, and the PHY samples them on the rising MDC edge.
- R5: On a read, MDIO is released from bit 46 (the first turnaround bit) to the end of the frame. The 16 bits sampled on rising MDC edges in slots 48..63 land in bits 15:0 of the word, first-received in bit 15.
- R6: On a read, bit 28 is set when the line is high in slot 47 (the second turnaround bit) and cleared when it is low. A write frame clears bit 28.
- R7: Busy clears on the falling MDC edge that follows the 64th rising edge, and exactly 64 rising MDC edges occur per frame.
- R8: Bus writes that arrive while busy is set are ignored; every field other than busy, fail and the read result keeps its launched value.
- R9: After a write frame, bits 15:0 still hold the write data and bits 31:30 hold what software wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the command word |
| wr_data_i | input | 32 | Command word to write |
| rd_data_o | output | 32 | Current command/status word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (resolved line) |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running frame. The rejection only shows after completion, in the fields and in the bits already on the wire. Each transaction therefore issues a conflicting write a few cycles after launch, then compares both the captured frame and the final word against values built from the launch word. The read failure path needs a PHY that stays silent in the turnaround slot, so the PHY model in the bench is switched off for every fifth address of a sweep over all 32 PHY addresses.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUSY_BIT  = 29;
  localparam int FAIL_BIT  = 28;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 5 + 5 + 2 + DATA_W;
  localparam int REL_IDX   = PRE_LEN + 2 + 2 + 5 + 5;
  localparam int TA2_IDX   = REL_IDX + 1;
  localparam int DAT_IDX   = REL_IDX + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [1:0] OP_RD = 2'b10;

  typedef struct packed {
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [4:0]        regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == CNT_W'(HALF_DIV - 1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic              is_rd_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic                 active_q, is_rd_q, ta_hi_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 last;
  logic                 start_rd;

  assign start_rd = (cmd_i.op == OP_RD);
  assign last     = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign done_o   = active_q && fall_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      is_rd_q  <= 1'b0;
      ta_hi_q  <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      rdata_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      is_rd_q  <= start_rd;
      ta_hi_q  <= 1'b0;
      idx_q    <= '0;
      frame_q  <= {{PRE_LEN{1'b1}}, 2'b01, cmd_i.op, cmd_i.phy, cmd_i.regad,
                   (start_rd ? 2'b11 : 2'b10), cmd_i.wdata};
    end else if (active_q) begin
      if (rise_i && is_rd_q) begin
        if (idx_q == IDX_W'(TA2_IDX)) ta_hi_q <= mdio_i;
        if (idx_q >= IDX_W'(DAT_IDX)) rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
      end
      if (fall_i) begin
        if (last) begin
          active_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  assign mdio_o    = active_q && frame_q[FRAME_LEN-1];
  assign mdio_oe_o = active_q && (!is_rd_q || (idx_q < IDX_W'(REL_IDX)));
  assign is_rd_o   = is_rd_q;
  assign fail_o    = is_rd_q && ta_hi_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              done_i,
  input  logic              is_rd_i,
  input  logic              fail_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [31:0]       word_o,
  output logic              busy_o,
  output logic              start_o
);
  logic [31:0] word_q;

  assign busy_o  = word_q[BUSY_BIT];
  assign start_o = wr_en_i && !busy_o && wr_data_i[BUSY_BIT];
  assign word_o  = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (wr_en_i && !busy_o) begin
      word_q <= wr_data_i;
    end else if (done_i) begin
      word_q[BUSY_BIT] <= 1'b0;
      word_q[FAIL_BIT] <= fail_i;
      if (is_rd_i) word_q[DATA_W-1:0] <= rdata_i;
    end
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  mdio_cmd_t         cmd;
  logic              busy, start, rise, fall, done, is_rd, fail;
  logic [DATA_W-1:0] rdata;

  assign cmd = mdio_cmd_t'(wr_data_i[27:0]);

  mdio_cmd_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .done_i (done), .is_rd_i(is_rd), .fail_i(fail), .rdata_i(rdata),
    .word_o (rd_data_o), .busy_o(busy), .start_o(start)
  );

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i, .rst_ni, .run_i(busy), .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_engine u_eng (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd), .rise_i(rise), .fall_i(fall),
    .mdio_i, .mdio_o, .mdio_oe_o, .done_o(done), .is_rd_o(is_rd),
    .fail_o(fail), .rdata_o(rdata)
  );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_data_o[29] && wr_data_i[29]) |=> rd_data_o[29]);

  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[29] |-> (!mdc_o && !mdio_oe_o));

  a_r4_hold_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r7_end_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[29]) |-> ($past(mdc_o) && !mdc_o));

  a_r8_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[29] && wr_en_i) |=> (rd_data_o[31:16] == {$past(rd_data_o[31:30]),
      rd_data_o[29:28], $past(rd_data_o[27:16])}));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/tb_mdio_cmd_master.sv
module tb_mdio_cmd_master;
  localparam int HALF_DIV = 2;

  logic        clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc, mdo, mdo_en, line;
  logic        phy_drv = 1'b0, phy_val = 1'b1;

  int checks = 0, fails = 0, cyc = 0, rc = 0, last_rise = 0, period = 0;
  bit responding = 0;
  logic [15:0] resp = '0;
  logic drv_v [64];
  logic drv_e [64];

  assign line = mdo_en ? mdo : (phy_drv ? phy_val : 1'b1);

  mdio_cmd_master #(.HALF_DIV(HALF_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdo_en), .mdio_i(line)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(posedge mdc) begin
    if (rc < 64) begin drv_v[rc] = mdo; drv_e[rc] = mdo_en; end
    if (rc > 0) period = cyc - last_rise;
    last_rise = cyc;
    rc++;
  end

  always @(negedge mdc) begin
    if (responding && rc == 47) begin phy_drv = 1; phy_val = 0; end
    else if (responding && rc >= 48 && rc <= 63) begin phy_drv = 1; phy_val = resp[63-rc]; end
    else phy_drv = 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] data, input logic [1:0] top, input bit respond,
                           input logic [15:0] rsp);
    logic [31:0] w, exp_w;
    logic [63:0] ef;
    bit rd, quiet;
    int bad, guard;
    rd = (op == 2'b10);
    w = {top, 1'b0, 1'b0, op, phy, rg, data};
    bus_write(w);
    chk(rd_data == w, "R1 readback", rd_data, w);
    quiet = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mdc || mdo_en || rd_data[29]) quiet = 0;
    end
    chk(quiet, "R2 no launch without start", {29'd0, mdc, mdo_en, rd_data[29]}, 32'd0);
    responding = respond; resp = rsp; rc = 0; phy_drv = 0;
    bus_write(w | 32'h2000_0000);
    chk(rd_data[29] == 1'b1, "R2 busy after start", {31'd0, rd_data[29]}, 32'd1);
    repeat (12) @(negedge clk);
    bus_write(~w | 32'h2000_0000);
    guard = 0;
    while (rd_data[29] && guard < 2000) begin @(negedge clk); guard++; end
    responding = 0;
    chk(rc == 64, "R7 rising edges per frame", rc, 64);
    chk(period == 2 * HALF_DIV, "R4 MDC period", period, 2 * HALF_DIV);
    ef = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, data};
    bad = 0;
    for (int b = 0; b < 64; b++) begin
      if (!rd || b < 46) begin
        if (drv_e[b] !== 1'b1 || drv_v[b] !== ef[63-b]) bad++;
      end else if (drv_e[b] !== 1'b0) bad++;
    end
    chk(bad == 0, rd ? "R5 read frame and release" : "R3 write frame bits", bad, 0);
    exp_w = {top, 1'b0, rd & ~respond, op, phy, rg, rd ? (respond ? rsp : 16'hFFFF) : data};
    chk(rd_data[27:16] == w[27:16], "R8 busy write ignored", rd_data, w);
    if (rd) begin
      chk(rd_data[28] == !respond, "R6 read fail flag", rd_data[28], !respond);
      chk(rd_data == exp_w, "R5 read result word", rd_data, exp_w);
    end else begin
      chk(rd_data == exp_w, "R9 write completion word", rd_data, exp_w);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_data == 32'd0 && !mdc && !mdo_en, "R1 reset state", rd_data, 32'd0);
    rst_ni = 1;
    @(negedge clk);
    bus_write(32'h1000_0000);
    chk(rd_data == 32'h1000_0000, "R1 fail bit writable idle", rd_data, 32'h1000_0000);
    run_frame(2'b01, 5'd3, 5'd9, 16'h1234, 2'b00, 0, 16'h0);
    chk(rd_data[28] == 1'b0, "R6 write clears fail", rd_data[28], 0);
    for (int a = 0; a < 32; a++) begin
      run_frame(2'b01, 5'(a), 5'(31 - a), 16'(a * 16'h0801) ^ 16'h5A5A, 2'(a), 0, 16'h0);
      run_frame(2'b10, 5'(a), 5'(a) ^ 5'h15, 16'hBEEF, 2'(a + 1), (a % 5) != 0,
                16'(a * 16'h1357) ^ 16'hC3A5);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule